// File: doc/BRIEF.md
# Serial Clock Divider with Duty Correction

This block makes the serial clock for a flash interface from the fast reference clock. A 5-bit code selects the division ratio. Codes 0 through 15 step the ratio by one, from 2 to 17. Codes 16 through 31 step it by two, from 18 to 48. An odd ratio leaves the high phase one reference cycle shorter than the low phase. A correction option moves the falling edge half a reference cycle later, so the two phases become equal. Two further options each lengthen one phase by a whole reference cycle: one the high phase, the other the low phase. These options suit devices that need more setup or hold time.

A mode input picks the idle level. In mode 0 the clock rests low. In mode 3 it rests high. Each period first leaves the idle level and then returns to it. Next to the clock, the block drives a one-cycle rise strobe and a one-cycle fall strobe. They tell the shift logic when the clock changes level.

A controller holds the run input high for as long as it wants clock periods. The configuration is captured when a run starts and is held for the whole run. Lowering the run input always finishes the current period before the clock returns to rest.

Top module: `sclk_divider`

## Requirements
- R1: Codes 0 to 15 give a period of code+2 reference cycles, so odd codes give odd ratios.
- R2: Codes 16 to 31 give a period of 2*code-14 reference cycles (18 up to 48, even only).
- R3: With no correction and no stretching, the high phase lasts floor(R/2) reference cycles and the low phase lasts ceil(R/2).
- R4: When correction is requested and R is odd, the high phase grows by half a reference cycle and the low phase shrinks by half. When R is even, the request changes nothing.
- R5: stretch_hi_i=1 adds one reference cycle to every high phase.
- R6: stretch_lo_i=1 adds one reference cycle to every low phase.
- R7: While stopped, sclk_o rests at idle_high_i (0 = mode 0, rests low; 1 = mode 3, rests high). Each period begins by leaving that level.
- R8: rise_o is high for exactly the reference cycle in which sclk_o has just risen. fall_o is high for the reference cycle in which the clock's fall is launched: sclk_o drops in that cycle without correction, or half a cycle later with correction. The two strobes never assert together.
- R9: The divider code and the option inputs are captured in the cycle a run starts. Changes to them while running have no effect on phase lengths or on the level the clock stops at.
- R10: run_i is sampled at the end of each period. If it is high, the next period follows with no gap. If it is low, the clock stops at the idle level. Holding run_i high for K cycles from rest yields 1+floor((K-1)/P) periods, where P is the full period.
- R11: During and directly after reset, sclk_o is low and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Request clock periods while high |
| div_code_i | input | 5 | Divider code selecting the ratio |
| duty_fix_i | input | 1 | Equalise phases for odd ratios |
| stretch_hi_i | input | 1 | Add one reference cycle to high phase |
| stretch_lo_i | input | 1 | Add one reference cycle to low phase |
| idle_high_i | input | 1 | Idle level: 0 low (mode 0), 1 high (mode 3) |
| sclk_o | output | 1 | Serial clock |
| rise_o | output | 1 | Rising-edge strobe |
| fall_o | output | 1 | Falling-edge strobe |

## Verification
A stop request can land in the same reference cycle as the end-of-period decision. Configuration inputs can also change in the cycle the divider returns to rest and picks up live settings again. The bench provokes the first case with hold lengths of exactly n*P and n*P+1 cycles, and judges it by counting the periods and checking the level the clock rests at. It provokes the second by scrambling every option just after a run starts and restoring it in the stop cycle. Every phase length is then compared with the lengths expected from the settings captured at start.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
  localparam int unsigned DIV_CODE_W = 5;
  localparam int unsigned LIN_CODES  = 16;
  localparam int unsigned MIN_RATIO  = 2;

  typedef struct packed {
    logic duty_fix;
    logic str_hi;
    logic str_lo;
    logic idle_hi;
  } sclk_opts_t;
endpackage

// File: rtl/sclk_ratio_map.sv
module sclk_ratio_map #(
  parameter int unsigned CODE_W    = 5,
  parameter int unsigned LIN_CODES = 16,
  parameter int unsigned MIN_RATIO = 2,
  parameter int unsigned MAX_RATIO = MIN_RATIO + LIN_CODES + 2 * ((2 ** CODE_W) - 1 - LIN_CODES),
  parameter int unsigned LEN_W     = $clog2(MAX_RATIO + 2)
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              str_hi_i,
  input  logic              str_lo_i,
  output logic [LEN_W-1:0]  hi_len_o,
  output logic [LEN_W-1:0]  lo_len_o,
  output logic              odd_o
);
  logic [LEN_W-1:0] ratio;
  logic [LEN_W-1:0] half;

  always_comb begin
    if (code_i < CODE_W'(LIN_CODES))
      ratio = LEN_W'(code_i) + LEN_W'(MIN_RATIO);
    else
      ratio = LEN_W'(MIN_RATIO + LIN_CODES) + (LEN_W'(code_i - CODE_W'(LIN_CODES)) << 1);
    half     = ratio >> 1;
    hi_len_o = half + LEN_W'(str_hi_i);
    lo_len_o = (ratio - half) + LEN_W'(str_lo_i);
    odd_o    = ratio[0];
  end

  always_comb begin
    AST_RATIO_RANGE: assert (ratio >= LEN_W'(MIN_RATIO) && ratio <= LEN_W'(MAX_RATIO)); // R2
    if (code_i < CODE_W'(LIN_CODES))
      AST_LIN_PARITY: assert (ratio[0] == code_i[0]); // R1
  end
endmodule

// File: rtl/sclk_phase_gen.sv
module sclk_phase_gen
  import sclk_div_pkg::*;
#(
  parameter int unsigned CODE_W = 5,
  parameter int unsigned LEN_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [CODE_W-1:0] code_i,
  input  sclk_opts_t        opts_i,
  input  logic [LEN_W-1:0]  lead_len_i,
  input  logic [LEN_W-1:0]  trail_len_i,
  output logic [CODE_W-1:0] eff_code_o,
  output sclk_opts_t        eff_opts_o,
  output logic              sclk_o,
  output logic              rise_o,
  output logic              fall_o
);
  logic              active_q, trail_q;
  logic [LEN_W-1:0]  cnt_q;
  logic              sclk_q, rise_q, fall_q;
  logic [CODE_W-1:0] code_q;
  sclk_opts_t        opts_q;

  // Live settings while at rest, captured ones while running
  assign eff_code_o = active_q ? code_q : code_i;
  assign eff_opts_o = active_q ? opts_q : opts_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      trail_q  <= 1'b0;
      cnt_q    <= '0;
      sclk_q   <= 1'b0;
      rise_q   <= 1'b0;
      fall_q   <= 1'b0;
      code_q   <= '0;
      opts_q   <= '0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (!active_q) begin
        code_q <= code_i;
        opts_q <= opts_i;
        if (run_i) begin
          active_q <= 1'b1;
          trail_q  <= 1'b0;
          cnt_q    <= lead_len_i - LEN_W'(1);
          sclk_q   <= ~opts_i.idle_hi;
          rise_q   <= ~opts_i.idle_hi;
          fall_q   <= opts_i.idle_hi;
        end else begin
          sclk_q <= opts_i.idle_hi;
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - LEN_W'(1);
      end else if (!trail_q) begin
        trail_q <= 1'b1;
        cnt_q   <= trail_len_i - LEN_W'(1);
        sclk_q  <= opts_q.idle_hi;
        rise_q  <= opts_q.idle_hi;
        fall_q  <= ~opts_q.idle_hi;
      end else if (run_i) begin
        trail_q <= 1'b0;
        cnt_q   <= lead_len_i - LEN_W'(1);
        sclk_q  <= ~opts_q.idle_hi;
        rise_q  <= ~opts_q.idle_hi;
        fall_q  <= opts_q.idle_hi;
      end else begin
        active_q <= 1'b0;
        trail_q  <= 1'b0;
      end
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_q && fall_q)); // R8
  AST_STOP_ON_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> $past(trail_q && cnt_q == '0 && !run_i)); // R10
  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && $past(active_q)) |-> ($stable(opts_q) && $stable(code_q))); // R9
  AST_REST_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && $past(!active_q && !run_i)) |-> (sclk_q == $past(opts_i.idle_hi))); // R7
endmodule

// File: rtl/sclk_duty_fix.sv
module sclk_duty_fix #(
  parameter bit FIX_EN = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fix_en_i,
  input  logic sclk_i,
  output logic sclk_o
);
  generate
    if (FIX_EN) begin : g_fix
      logic half_q;
      // Half-cycle-late copy; OR delays only the falling edge
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) half_q <= 1'b0;
        else         half_q <= sclk_i;
      end
      assign sclk_o = sclk_i | (fix_en_i & half_q);
    end else begin : g_nofix
      logic unused_fix;
      assign unused_fix = fix_en_i;
      assign sclk_o     = sclk_i;
    end
  endgenerate
endmodule

// File: rtl/sclk_divider.sv
module sclk_divider
  import sclk_div_pkg::*;
#(
  parameter int unsigned CODE_W    = DIV_CODE_W,
  parameter int unsigned LIN_N     = LIN_CODES,
  parameter int unsigned MIN_R     = MIN_RATIO,
  parameter bit          DUTY_FIX  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [CODE_W-1:0] div_code_i,
  input  logic              duty_fix_i,
  input  logic              stretch_hi_i,
  input  logic              stretch_lo_i,
  input  logic              idle_high_i,
  output logic              sclk_o,
  output logic              rise_o,
  output logic              fall_o
);
  localparam int unsigned MAX_R = MIN_R + LIN_N + 2 * ((2 ** CODE_W) - 1 - LIN_N);
  localparam int unsigned LEN_W = $clog2(MAX_R + 2);

  sclk_opts_t        opts, eff_opts;
  logic [CODE_W-1:0] eff_code;
  logic [LEN_W-1:0]  hi_len, lo_len, lead_len, trail_len;
  logic              ratio_odd, fix_en, sclk_q;

  assign opts = '{duty_fix: duty_fix_i, str_hi: stretch_hi_i,
                  str_lo: stretch_lo_i, idle_hi: idle_high_i};

  sclk_ratio_map #(
    .CODE_W(CODE_W), .LIN_CODES(LIN_N), .MIN_RATIO(MIN_R),
    .MAX_RATIO(MAX_R), .LEN_W(LEN_W)
  ) u_map (
    .code_i  (eff_code),
    .str_hi_i(eff_opts.str_hi),
    .str_lo_i(eff_opts.str_lo),
    .hi_len_o(hi_len),
    .lo_len_o(lo_len),
    .odd_o   (ratio_odd)
  );

  // Lead phase is the one away from the idle level
  assign lead_len  = eff_opts.idle_hi ? lo_len : hi_len;
  assign trail_len = eff_opts.idle_hi ? hi_len : lo_len;
  assign fix_en    = eff_opts.duty_fix & ratio_odd;

  sclk_phase_gen #(.CODE_W(CODE_W), .LEN_W(LEN_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .code_i     (div_code_i),
    .opts_i     (opts),
    .lead_len_i (lead_len),
    .trail_len_i(trail_len),
    .eff_code_o (eff_code),
    .eff_opts_o (eff_opts),
    .sclk_o     (sclk_q),
    .rise_o     (rise_o),
    .fall_o     (fall_o)
  );

  sclk_duty_fix #(.FIX_EN(DUTY_FIX)) u_fix (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fix_en_i(fix_en),
    .sclk_i  (sclk_q),
    .sclk_o  (sclk_o)
  );

  AST_CORR_LATE_FALL: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (DUTY_FIX && fix_en && $fell(sclk_q)) |-> sclk_o); // R4
  AST_RISE_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (sclk_o && !$past(sclk_q))); // R8
endmodule

// File: tb/sclk_divider_bench.sv
module sclk_divider_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [4:0] code = '0;
  logic       dfix = 1'b0, shi = 1'b0, slo = 1'b0, mode3 = 1'b0;
  logic       sclk, rise, fall;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sclk_divider u_sclk_divider (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .div_code_i(code),
    .duty_fix_i(dfix), .stretch_hi_i(shi), .stretch_lo_i(slo),
    .idle_high_i(mode3), .sclk_o(sclk), .rise_o(rise), .fall_o(fall)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ratio_f(input int c);
    if (c < 16) return c + 2;
    return 18 + 2 * (c - 16);
  endfunction

  // Monitor state
  bit    mon_en = 0, first_skip = 0, exp_fix = 0, exp_idle = 0, pend_fall = 0;
  int    exp_hi_h = 0, exp_lo_h = 0, dur = 0, lead_cnt = 0;
  bit    prev = 0;
  string tag_hi = "", tag_lo = "";

  task automatic sample(input bit at_pos);
    bit lvl, rose_now, fell_now;
    lvl = sclk;
    rose_now = lvl && !prev;
    fell_now = !lvl && prev;
    if (mon_en) begin
      if (at_pos) begin
        chk(rise == rose_now, "R8 rise strobe", rise, rose_now);
        if (!exp_fix) chk(fall == fell_now, "R8 fall strobe", fall, fell_now);
        else begin
          chk(!fell_now, "R4 fall deferred", fell_now, 0);
          pend_fall = fall;
        end
      end else begin
        chk(!rose_now, "R8 rise off-edge", rose_now, 0);
        if (exp_fix) chk(fell_now == pend_fall, "R8 R4 fall after strobe", fell_now, pend_fall);
        else chk(!fell_now, "R8 fall off-edge", fell_now, 0);
      end
      if (lvl != prev) begin
        if (!first_skip) begin
          if (prev) chk(dur == exp_hi_h, tag_hi, dur, exp_hi_h);
          else      chk(dur == exp_lo_h, tag_lo, dur, exp_lo_h);
        end
        first_skip = 0;
        if (lvl != exp_idle) lead_cnt++;
        dur = 1;
      end else dur++;
    end
    prev = lvl;
  endtask

  initial begin
    forever begin
      @(posedge clk); #1; sample(1'b1);
      @(negedge clk); #1; sample(1'b0);
    end
  end

  task automatic run_case(input int c, input bit df, input bit sh, input bit sl,
                          input bit m3, input int k);
    int r, hi, lo, p, exp_per;
    string rtag;
    r  = ratio_f(c);
    hi = r / 2 + sh;
    lo = r - r / 2 + sl;
    p  = hi + lo;
    exp_per = 1 + (k - 1) / p;
    rtag = (c < 16) ? "R1" : "R2";
    @(posedge clk); #3;
    code = c[4:0]; dfix = df; shi = sh; slo = sl; mode3 = m3;
    repeat (3) @(posedge clk);
    #3;
    exp_fix  = df && (r % 2 == 1);
    exp_idle = m3;
    exp_hi_h = 2 * hi + (exp_fix ? 1 : 0);
    exp_lo_h = 2 * lo - (exp_fix ? 1 : 0);
    tag_hi = $sformatf("%s %s %s high phase code=%0d", rtag, exp_fix ? "R4" : "R3",
                       sh ? "R5" : "R9", c);
    tag_lo = $sformatf("%s %s %s low phase code=%0d", rtag, exp_fix ? "R4" : "R3",
                       sl ? "R6" : "R9", c);
    first_skip = 1; lead_cnt = 0; dur = 0; pend_fall = 0; prev = sclk;
    mon_en = 1;
    run = 1'b1;
    if (k >= 2) begin
      @(posedge clk); #3;
      code = 5'($urandom_range(31)); dfix = ~df; shi = ~sh; slo = ~sl; mode3 = ~m3;
      repeat (k - 1) @(posedge clk);
      #3;
      code = c[4:0]; dfix = df; shi = sh; slo = sl; mode3 = m3;
      run = 1'b0;
    end else begin
      repeat (k) @(posedge clk);
      #3;
      run = 1'b0;
    end
    repeat (p + 10) @(posedge clk);
    #2;
    chk(lead_cnt == exp_per, "R10 period count", lead_cnt, exp_per);
    chk(sclk == m3, "R7 R10 rest level after stop", sclk, m3);
    mon_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #(CLK_PERIOD * 2 + 3);
    chk(sclk == 1'b0, "R11 sclk in reset", sclk, 0);
    chk(!rise && !fall, "R11 strobes in reset", rise | fall, 0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk(sclk == 1'b0, "R11 sclk after reset", sclk, 0);
    chk(!rise && !fall, "R11 strobes after reset", rise | fall, 0);

    run_case(0, 0, 0, 0, 0, 5);    // R1 minimum ratio
    run_case(1, 1, 0, 0, 0, 7);    // R4 ratio 3 corrected
    run_case(15, 0, 0, 0, 1, 40);  // R1 ratio 17, R7 mode 3
    run_case(16, 0, 1, 0, 0, 40);  // R2 first even step, R5
    run_case(31, 1, 0, 1, 1, 100); // R2 top, R4 even ignored, R6
    run_case(7, 1, 1, 1, 1, 30);   // R4 R5 R6 combined in mode 3
    run_case(3, 0, 0, 0, 0, 10);   // R10 stop at exact boundary
    run_case(3, 0, 0, 0, 0, 11);   // R10 one cycle past boundary
    run_case(2, 0, 0, 0, 1, 1);    // R10 single-cycle request
    for (int i = 0; i < 30; i++) begin
      int c, r;
      c = int'($urandom_range(31));
      r = ratio_f(c);
      run_case(c, 1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)),
               1'($urandom_range(1)), 1 + int'($urandom_range(3 * r + 4)));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule